// File: doc/BRIEF.md
# DRAM Refresh Pacer

The refresh pacer keeps dynamic or pseudo-static memory alive. It asks the bus unit for a dummy memory read at regular intervals and supplies the address that read should use. A down-counter sets the spacing between requests. Its reload value comes from a programmable interval register, so software picks how many clocks pass between refreshes. The request is a level: once raised, it stays high until the bus unit acknowledges it.

Each accepted acknowledge advances a 12-bit row counter. The row counter sits just above the byte bit of the 20-bit refresh address. A programmable 7-bit base fills the top of the address, which places the refreshed region on any 8 KB boundary.

Software reaches the block through a small word-wide register port:

| Offset | Register | Contents |
|---|---|---|
| 0 | interval | bits 8:0 |
| 1 | base | bits 6:0 |
| 2 | control | bit 0 is the enable |
| 3 | status | read only; returns the live count |

Unused bits read as zero.

Top module: `dram_refresh_ctl`

## Requirements
- R1: After reset the request is low, the refresh address is zero, and the status register (offset 3) reads zero.
- R2: While enabled, with requests acknowledged promptly, successive request rising edges are exactly interval+1 clocks apart. The interval is the value at offset 0, bits 8:0.
- R3: The refresh address carries the base (offset 1, bits 6:0) on bits 19:13 and the row counter on bits 12:1. Bit 0 is always 0.
- R4: A raised request stays high until acknowledged. The row counter does not move without an acknowledge.
- R5: Each clock in which the acknowledge is high while the request is high advances the row counter by one.
- R6: Clearing the enable (offset 2, bit 0) drops the request within one clock. While disabled, the counter rests at the interval value and no request is raised.
- R7: An interval write while enabled does not change the period in progress. It applies from the next reload.
- R8: The row counter wraps from 4095 to 0.
- R9: While enabled, the status register reads the live count, which falls by one per clock until it reaches zero.
- R10: If a refresh falls due in the same clock as an acknowledge, the request stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| rfsh_req | output | 1 | Refresh request to the bus unit |
| rfsh_ack | input | 1 | Bus unit accepts the refresh |
| rfsh_addr | output | 20 | Refresh address |

## Verification
The row wrap is the hardest state to reach from the ports, because it takes 4096 accepted refreshes. The stimulus reaches it by setting the interval to zero and acknowledging in every clock. That makes a refresh fall due in the same clock as each acknowledge, so the same run also exercises the case where a new request must survive an acknowledge. The scoreboard compares every refresh address across the wrap, and the monitor confirms that the request never fell during the run.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
   localparam int RA_W = 2;

   typedef enum logic [RA_W-1:0] {
      RA_INTERVAL = 2'd0,
      RA_BASE     = 2'd1,
      RA_CTRL     = 2'd2,
      RA_STATUS   = 2'd3
   } rfsh_reg_e;
endpackage

// File: rtl/rfsh_regfile.sv
module rfsh_regfile
   import rfsh_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 9,
   parameter int BASE_W   = 7,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [CNT_W-1:0]  count_i,
   output logic [CNT_W-1:0]  interval_o,
   output logic [BASE_W-1:0] base_o,
   output logic              en_o
);
   if (CNT_W > DATA_W || BASE_W > DATA_W) begin : g_bad_width
      $error("rfsh_regfile: field wider than data port");
   end

   logic [CNT_W-1:0]  interval_q;
   logic [BASE_W-1:0] base_q;
   logic              en_q;
   logic [DATA_W-1:0] rd_mux;
   logic              unused_wdata;

   assign unused_wdata = ^reg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         interval_q <= '0;
         base_q     <= '0;
         en_q       <= 1'b0;
      end else if (reg_wr) begin
         case (rfsh_reg_e'(reg_addr))
            RA_INTERVAL: interval_q <= reg_wdata[CNT_W-1:0];
            RA_BASE:     base_q     <= reg_wdata[BASE_W-1:0];
            RA_CTRL:     en_q       <= reg_wdata[0];
            default:     ;
         endcase
      end
   end

   always_comb begin
      rd_mux = '0;
      case (rfsh_reg_e'(reg_addr))
         RA_INTERVAL: rd_mux[CNT_W-1:0]  = interval_q;
         RA_BASE:     rd_mux[BASE_W-1:0] = base_q;
         RA_CTRL:     rd_mux[0]          = en_q;
         RA_STATUS:   rd_mux[CNT_W-1:0]  = count_i;
         default:     rd_mux             = '0;
      endcase
   end

   if (READ_REG) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) reg_rdata <= '0;
         else        reg_rdata <= rd_mux;
      end
   end else begin : g_rd_comb
      assign reg_rdata = rd_mux;
   end

   assign interval_o = interval_q;
   assign base_o     = base_q;
   assign en_o       = en_q;
endmodule

// File: rtl/rfsh_pacer.sv
module rfsh_pacer #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [CNT_W-1:0] interval_i,
   input  logic             ack_i,
   output logic [CNT_W-1:0] count_o,
   output logic             req_o
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("rfsh_pacer: CNT_W must be positive");
   end

   logic [CNT_W-1:0] count_q;
   logic             req_q;
   logic             due;

   assign due = en_i && (count_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count_q <= '0;
      else if (!en_i || due)     count_q <= interval_i;
      else                       count_q <= count_q - CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       req_q <= 1'b0;
      else if (!en_i)   req_q <= 1'b0;
      else if (due)     req_q <= 1'b1;
      else if (ack_i)   req_q <= 1'b0;
   end

   assign count_o = count_q;
   assign req_o   = req_q;

   p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && count_q == '0) |=> (count_q == $past(interval_i) && req_q));
   p_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && count_q != '0) |=> (count_q == $past(count_q) - CNT_W'(1)));
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && req_q && !ack_i) |=> req_q);
   p_due_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && count_q == '0 && ack_i) |=> req_q);
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
   parameter int ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   output logic [ROW_W-1:0] row_o
);
   if (ROW_W < 1) begin : g_bad_row
      $error("rfsh_row_ctr: ROW_W must be positive");
   end

   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     row_q <= '0;
      else if (adv_i) row_q <= row_q + ROW_W'(1);
   end

   assign row_o = row_q;

   p_row_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && row_q != '1) |=> (row_q == $past(row_q) + ROW_W'(1)));
   p_row_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && row_q == '1) |=> (row_q == '0));
   p_row_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(row_q));
endmodule

// File: rtl/dram_refresh_ctl.sv
module dram_refresh_ctl
   import rfsh_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 9,
   parameter int ROW_W    = 12,
   parameter int BASE_W   = 7,
   parameter bit READ_REG = 1'b0,
   localparam int ADDR_W  = BASE_W + ROW_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              rfsh_req,
   input  logic              rfsh_ack,
   output logic [ADDR_W-1:0] rfsh_addr
);
   logic [CNT_W-1:0]  count;
   logic [CNT_W-1:0]  interval;
   logic [BASE_W-1:0] base;
   logic [ROW_W-1:0]  row;
   logic              en;
   logic              accept;

   rfsh_regfile #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .BASE_W(BASE_W), .READ_REG(READ_REG)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_i(count),
      .interval_o(interval), .base_o(base), .en_o(en)
   );

   rfsh_pacer #(.CNT_W(CNT_W)) pacer_i (
      .clk(clk), .rst_n(rst_n), .en_i(en), .interval_i(interval),
      .ack_i(rfsh_ack), .count_o(count), .req_o(rfsh_req)
   );

   assign accept = rfsh_req && rfsh_ack;

   rfsh_row_ctr #(.ROW_W(ROW_W)) row_i (
      .clk(clk), .rst_n(rst_n), .adv_i(accept), .row_o(row)
   );

   assign rfsh_addr = {base, row, 1'b0};

   p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !rfsh_req);
   p_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (count == $past(interval)));
   p_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (rfsh_addr[0] == 1'b0 && rfsh_addr[ADDR_W-1 -: BASE_W] == base));
endmodule

// File: tb/dram_refresh_ctl_tb_top.sv
module dram_refresh_ctl_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        rfsh_req;
   logic        rfsh_ack = 1'b0;
   logic [19:0] rfsh_addr;

   int          n_chk = 0;
   int          n_fail = 0;
   logic [19:0] exp_q[$];
   int          pops = 0;
   bit          auto_ack = 1'b0;
   int          cyc = 0;
   int          rises[$];
   logic        req_d = 1'b0;
   logic [6:0]  base_m = '0;
   logic [11:0] row_m = '0;
   string       tag = "R3 R5";
   logic [15:0] rv;
   logic [19:0] a0;

   always #(CLK_P/2) clk = ~clk;

   dram_refresh_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rfsh_req(rfsh_req),
      .rfsh_ack(rfsh_ack), .rfsh_addr(rfsh_addr)
   );

   task automatic chk(input bit ok, input string r, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
      end
   endtask

   task automatic push_exp(input int n);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back({base_m, row_m, 1'b0});
         row_m = row_m + 12'd1;
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_now(input logic [1:0] a, output logic [15:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic wait_pops(input int target);
      while (pops < target) @(negedge clk);
   endtask

   // monitor: scoreboard compare on every acknowledge
   always @(negedge clk) begin
      cyc++;
      if (rfsh_req && !req_d) rises.push_back(cyc);
      req_d = rfsh_req;
      if (auto_ack && rfsh_req && exp_q.size() > 0) begin
         logic [19:0] e;
         e = exp_q.pop_front();
         chk(rfsh_addr == e, tag, "refresh address", rfsh_addr, e);
         pops++;
         rfsh_ack = 1'b1;
      end else begin
         rfsh_ack = 1'b0;
      end
   end

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      int tgt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(rfsh_req == 1'b0, "R1", "req after reset", rfsh_req, 0);
      chk(rfsh_addr == '0, "R1", "addr after reset", rfsh_addr, 0);
      rd_now(2'd3, rv);
      chk(rv == 16'd0, "R1", "status after reset", rv, 0);

      // R2 period, R3/R5 addresses
      base_m = 7'h55; tag = "R3 R5";
      rises.delete();
      push_exp(3);
      tgt = pops + 3;
      wr(2'd0, 16'd5);
      wr(2'd1, 16'h55);
      wr(2'd2, 16'd1);
      auto_ack = 1'b1;
      wait_pops(tgt);
      auto_ack = 1'b0;
      chk(rises.size() >= 3, "R2", "rise count", rises.size(), 3);
      if (rises.size() >= 3) begin
         chk(rises[1] - rises[0] == 6, "R2", "period a", rises[1] - rises[0], 6);
         chk(rises[2] - rises[1] == 6, "R2", "period b", rises[2] - rises[1], 6);
      end

      // R4 pending request holds, row still
      while (!rfsh_req) @(negedge clk);
      a0 = rfsh_addr;
      repeat (15) @(negedge clk);
      chk(rfsh_req == 1'b1, "R4", "req held unacked", rfsh_req, 1);
      chk(rfsh_addr == a0, "R4", "row still without ack", rfsh_addr, a0);

      // R6 disable drops request
      wr(2'd2, 16'd0);
      @(negedge clk);
      chk(rfsh_req == 1'b0, "R6", "req after disable", rfsh_req, 0);
      rd_now(2'd3, rv);
      chk(rv == 16'd5, "R6", "count rests at interval", rv, 5);
      repeat (10) @(negedge clk);
      chk(rfsh_req == 1'b0, "R6", "no req while disabled", rfsh_req, 0);
      rd_now(2'd3, rv);
      chk(rv == 16'd5, "R6", "count stopped", rv, 5);

      // R7 interval write applies from next reload
      tag = "R3 R5";
      rises.delete();
      push_exp(3);
      tgt = pops + 3;
      wr(2'd2, 16'd1);
      auto_ack = 1'b1;
      while (rises.size() < 1) @(negedge clk);
      wr(2'd0, 16'd9);
      wait_pops(tgt);
      auto_ack = 1'b0;
      chk(rises.size() >= 3, "R7", "rise count", rises.size(), 3);
      if (rises.size() >= 3) begin
         chk(rises[1] - rises[0] == 6, "R7", "old period kept", rises[1] - rises[0], 6);
         chk(rises[2] - rises[1] == 10, "R7", "new period", rises[2] - rises[1], 10);
      end
      wr(2'd2, 16'd0);

      // R9 live count
      wr(2'd0, 16'd20);
      wr(2'd2, 16'd1);
      rd_now(2'd3, rv);
      chk(rv == 16'd20, "R9", "count at start", rv, 20);
      @(negedge clk);
      rd_now(2'd3, rv);
      chk(rv == 16'd19, "R9", "count step 1", rv, 19);
      @(negedge clk);
      rd_now(2'd3, rv);
      chk(rv == 16'd18, "R9", "count step 2", rv, 18);
      wr(2'd2, 16'd0);

      // R8 row wrap, R10 due with ack keeps req
      base_m = 7'h7F; tag = "R8 R3 R5";
      wr(2'd1, 16'h7F);
      wr(2'd0, 16'd0);
      repeat (2) @(negedge clk);
      rises.delete();
      push_exp(4100);
      tgt = pops + 4100;
      wr(2'd2, 16'd1);
      auto_ack = 1'b1;
      wait_pops(tgt);
      auto_ack = 1'b0;
      chk(rises.size() == 1, "R10", "req never fell", rises.size(), 1);
      chk(rfsh_req == 1'b1, "R10", "req still high", rfsh_req, 1);
      wr(2'd2, 16'd0);
      @(negedge clk);
      chk(rfsh_req == 1'b0, "R6", "req after final disable", rfsh_req, 0);

      finish_run();
   end
endmodule